// File: doc/BRIEF.md
# Second-order delta-sigma modulator for a 1-bit DAC

The block converts a 24-bit data word into a single-bit pulse-density stream that drives a 1-bit DAC followed by analog smoothing. A second-order noise-shaping loop runs at a sample rate obtained by dividing the system clock by eight, so a 2.5 MHz system clock gives a 312.5 kHz sample rate. Every sample period the loop emits one output bit. Over a long run, the fraction of ones equals the selected input code divided by 2^20.

A host presents a word on `data_in` and pulses `data_load` once the word's last significant bit has arrived. Only a loaded word reaches the loop. Two control inputs choose how the word is read: `res_hi` picks 20 or 16 significant bits, and `fmt_offset` picks two's complement or offset binary coding. Both codings are mapped onto one internal unsigned scale. A synchronous `clear` zeroes the stored word. `sleep` freezes the loop and silences the output.

Top module: `ds2_dac_mod`

## Requirements
- R1: `sample_tick` is high for exactly one system clock out of every 8. After reset is released, the first tick comes in the 8th clock, and `bit_out` can change only in the clock after a tick.
- R2: With offset binary coding (`fmt_offset`=1) and 20-bit resolution (`res_hi`=1), the number of ones in 1024 consecutive samples is within 8 of 1024*u/2^20, where u is data bits 23..4. This is checked at u = 2^18 and u = 3*2^18.
- R3: With `res_hi`=0, only data bits 23..8 count, as if bits 7..4 were zero. With `res_hi`=1, bits 23..4 count. Bits 3..0 never count. The stream follows the second-order loop sample for sample.
- R4: With `fmt_offset`=0, the word is read as two's complement: the value is u with bit 19 inverted. So word 0x000000 gives a density of 1/2 and word 0xC00000 gives 1/4.
- R5: While `clear` is high, the stored word is zero, and it stays zero after `clear` falls until the next load. This gives a density of 1/2 with two's complement coding and no ones (at most 8 in 1024 samples) with offset binary coding.
- R6: A change on `data_in` without `data_load` does not change the output stream.
- R7: While `sleep` is high, `bit_out` is 0 and both integrators and the output decision hold their values. When `sleep` falls, the stream continues from where it stopped.
- R8: During reset, `bit_out` and `sample_tick` are 0 and both integrators are cleared.
- R9: Both integrators saturate instead of wrapping. Offset binary word 0x000000 gives at most 8 ones in 1024 samples, and word 0xFFFFFF gives at least 1016.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 24 | Data word, MSB at bit 23 |
| data_load | input | 1 | One-cycle strobe that stores `data_in` |
| res_hi | input | 1 | 1: 20 significant bits; 0: 16 significant bits |
| fmt_offset | input | 1 | 1: offset binary coding; 0: two's complement coding |
| clear | input | 1 | Synchronous clear of the stored word |
| sleep | input | 1 | Freezes the loop and forces the output low |
| sample_tick | output | 1 | One-cycle strobe at the modulator sample rate |
| bit_out | output | 1 | Single-bit modulator output |

## Verification
The bench builds the block with its default parameters: a 24-bit word, 20 and 16 significant bits, a divide-by-8 sample clock, and integrator guard widths of 3 and 5 bits. These values make the truncation mask, the MSB inversion for two's complement, and the clamp of both integrators take part in every sample. A behavioural model built from integers predicts each output bit. Density windows of 1024 samples test mid-scale, quarter-scale, cleared, truncated and full-scale codes. Resets placed before the full-scale and zero-scale runs drive the second integrator into its clamp from a known start.

// File: rtl/ds2_pkg.sv
package ds2_pkg;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;

    typedef enum logic {
        RES_LOW  = 1'b0,
        RES_HIGH = 1'b1
    } res_e;

endpackage

// File: rtl/ds2_tick_gen.sv
module ds2_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST);

endmodule

// File: rtl/ds2_word_map.sv
module ds2_word_map
    import ds2_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int HI_W   = 20,
    parameter int LO_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DATA_W-1:0]      data_i,
    input  logic                   load_i,
    input  logic                   clear_i,
    input  res_e                   res_i,
    input  fmt_e                   fmt_i,
    output logic [DATA_W-1:0]      word_o,
    output logic signed [HI_W-1:0] centered_o
);
    localparam int DROP = HI_W - LO_W;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    logic [HI_W-1:0] top_bits;
    logic [HI_W-1:0] trunc;
    logic [HI_W-1:0] unsig;

    // Stored word: clear wins over a simultaneous load.
    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.word = '0;
        end else if (load_i) begin
            st_d.word = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_bits = st_q.word[DATA_W-1 -: HI_W];

    generate
        if (DROP > 0) begin : g_trunc
            localparam logic [HI_W-1:0] KEEP_MASK = {{LO_W{1'b1}}, {DROP{1'b0}}};
            assign trunc = (res_i == RES_HIGH) ? top_bits : (top_bits & KEEP_MASK);
        end else begin : g_full
            assign trunc = top_bits;
        end
    endgenerate

    // Both codings end up as an unsigned code on one common scale.
    assign unsig = (fmt_i == FMT_OFFSET) ? trunc
                                         : {~trunc[HI_W-1], trunc[HI_W-2:0]};

    // Centre the unsigned code around zero for the loop.
    assign centered_o = signed'({~unsig[HI_W-1], unsig[HI_W-2:0]});
    assign word_o     = st_q.word;

endmodule

// File: rtl/ds2_loop2.sv
module ds2_loop2 #(
    parameter int IN_W = 20,
    parameter int G1   = 3,
    parameter int G2   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic                        hold_i,
    input  logic signed [IN_W-1:0]      x_i,
    output logic                        bit_o,
    output logic signed [IN_W+G1-1:0]   acc1_o,
    output logic signed [IN_W+G2-1:0]   acc2_o,
    output logic                        v_o
);
    localparam int W1 = IN_W + G1;
    localparam int W2 = IN_W + G2;
    localparam int SW = W2 + 2;

    localparam logic signed [SW-1:0] MAX1 = {{(SW-W1+1){1'b0}}, {(W1-1){1'b1}}};
    localparam logic signed [SW-1:0] MIN1 = {{(SW-W1+1){1'b1}}, {(W1-1){1'b0}}};
    localparam logic signed [SW-1:0] MAX2 = {{(SW-W2+1){1'b0}}, {(W2-1){1'b1}}};
    localparam logic signed [SW-1:0] MIN2 = {{(SW-W2+1){1'b1}}, {(W2-1){1'b0}}};
    localparam logic signed [SW-1:0] FB_HI = {{(SW-IN_W){1'b0}}, 1'b1, {(IN_W-1){1'b0}}};
    localparam logic signed [SW-1:0] FB_LO = {{(SW-IN_W+1){1'b1}}, {(IN_W-1){1'b0}}};

    typedef struct packed {
        logic signed [W1-1:0] x1;
        logic signed [W2-1:0] x2;
        logic                 v;
    } st_t;

    st_t st_d, st_q;

    logic signed [SW-1:0] fb;
    logic signed [SW-1:0] sum1;
    logic signed [SW-1:0] sum2;
    logic signed [SW-1:0] new1;
    logic signed [SW-1:0] new2;

    function automatic logic signed [SW-1:0] clamp(
        input logic signed [SW-1:0] val,
        input logic signed [SW-1:0] hi,
        input logic signed [SW-1:0] lo
    );
        if (val > hi) begin
            return hi;
        end else if (val < lo) begin
            return lo;
        end
        return val;
    endfunction

    always_comb begin
        st_d = st_q;
        fb   = st_q.v ? FB_HI : FB_LO;
        sum1 = SW'(st_q.x1) + SW'(x_i) - fb;
        new1 = clamp(sum1, MAX1, MIN1);
        sum2 = SW'(st_q.x2) + new1 - fb;
        new2 = clamp(sum2, MAX2, MIN2);
        if (tick_i && !hold_i) begin
            st_d.x1 = W1'(new1);
            st_d.x2 = W2'(new2);
            st_d.v  = (new2 >= 0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o  = st_q.v & ~hold_i;
    assign acc1_o = st_q.x1;
    assign acc2_o = st_q.x2;
    assign v_o    = st_q.v;

endmodule

// File: rtl/ds2_dac_mod.sv
module ds2_dac_mod
    import ds2_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int HI_W   = 20,
    parameter int LO_W   = 16,
    parameter int DIV    = 8,
    parameter int G1     = 3,
    parameter int G2     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_load,
    input  logic              res_hi,
    input  logic              fmt_offset,
    input  logic              clear,
    input  logic              sleep,
    output logic              sample_tick,
    output logic              bit_out
);
    localparam int W1 = HI_W + G1;
    localparam int W2 = HI_W + G2;

    logic [DATA_W-1:0]      word_w;
    logic signed [HI_W-1:0] centered_w;
    logic signed [W1-1:0]   acc1_w;
    logic signed [W2-1:0]   acc2_w;
    logic                   v_w;

    ds2_tick_gen #(
        .DIV (DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (sample_tick)
    );

    ds2_word_map #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W),
        .LO_W   (LO_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_i     (data_in),
        .load_i     (data_load),
        .clear_i    (clear),
        .res_i      (res_e'(res_hi)),
        .fmt_i      (fmt_e'(fmt_offset)),
        .word_o     (word_w),
        .centered_o (centered_w)
    );

    ds2_loop2 #(
        .IN_W (HI_W),
        .G1   (G1),
        .G2   (G2)
    ) u_loop (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sample_tick),
        .hold_i (sleep),
        .x_i    (centered_w),
        .bit_o  (bit_out),
        .acc1_o (acc1_w),
        .acc2_o (acc2_w),
        .v_o    (v_w)
    );

endmodule

// File: rtl/ds2_dac_mod_chk.sv
module ds2_dac_mod_chk #(
    parameter int DIV    = 8,
    parameter int DATA_W = 24,
    parameter int W1     = 23,
    parameter int W2     = 25
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep,
    input logic                 clear,
    input logic                 sample_tick,
    input logic                 bit_out,
    input logic [DATA_W-1:0]    word,
    input logic signed [W1-1:0] acc1,
    input logic signed [W2-1:0] acc2,
    input logic                 v
);
    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= 0;
        end else if (sample_tick) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    AST_TICK_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> (gap_q == DIV - 1)); // R1
    AST_TICK_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == DIV - 1) |-> sample_tick); // R1
    AST_DECISION_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(v)); // R1
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word == '0)); // R5
    AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !bit_out); // R7
    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(acc1) && $stable(acc2) && $stable(v))); // R7

endmodule

bind ds2_dac_mod ds2_dac_mod_chk #(
    .DIV    (DIV),
    .DATA_W (DATA_W),
    .W1     (W1),
    .W2     (W2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .clear       (clear),
    .sample_tick (sample_tick),
    .bit_out     (bit_out),
    .word        (word_w),
    .acc1        (acc1_w),
    .acc2        (acc2_w),
    .v           (v_w)
);

// File: tb/test_ds2_dac_mod.sv
module test_ds2_dac_mod;
    localparam int CLK_P = 10;
    localparam int NWIN  = 1024;
    localparam int SKIP  = 32;
    localparam int TOL   = 8;
    localparam longint HALF = 64'd524288;
    localparam longint LIM1 = 64'd4194304;
    localparam longint LIM2 = 64'd16777216;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] data_in = '0;
    logic        data_load = 1'b0;
    logic        res_hi = 1'b1;
    logic        fmt_offset = 1'b1;
    logic        clear = 1'b0;
    logic        sleep = 1'b0;
    logic        sample_tick;
    logic        bit_out;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R8";

    // behavioural reference state
    int          m_cnt = 0;
    logic [23:0] m_word = '0;
    longint      m_x1 = 0;
    longint      m_x2 = 0;
    bit          m_v = 1'b0;

    ds2_dac_mod i_ds2_dac_mod (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_in     (data_in),
        .data_load   (data_load),
        .res_hi      (res_hi),
        .fmt_offset  (fmt_offset),
        .clear       (clear),
        .sleep       (sleep),
        .sample_tick (sample_tick),
        .bit_out     (bit_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic longint clampl(longint val, longint lim);
        if (val > lim - 1) return lim - 1;
        if (val < -lim) return -lim;
        return val;
    endfunction

    function automatic longint code_of(logic [23:0] w, bit res, bit fmt);
        logic [19:0] t;
        longint u;
        t = w[23:4];
        if (!res) t[3:0] = 4'h0;
        if (!fmt) t[19] = ~t[19];
        u = longint'(t);
        return u;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_word = '0; m_x1 = 0; m_x2 = 0; m_v = 1'b0;
        end else begin
            if (m_cnt == 7 && !sleep) begin
                longint s, fb;
                s = code_of(m_word, res_hi, fmt_offset) - HALF;
                fb = m_v ? HALF : -HALF;
                m_x1 = clampl(m_x1 + s - fb, LIM1);
                m_x2 = clampl(m_x2 + m_x1 - fb, LIM2);
                m_v = (m_x2 >= 0);
            end
            m_cnt = (m_cnt + 1) % 8;
            if (clear) m_word = '0;
            else if (data_load) m_word = data_in;
        end
    end

    // per-cycle comparison a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            bit exp_bit;
            exp_bit = sleep ? 1'b0 : m_v;
            check(bit_out == exp_bit, cur_req, longint'(bit_out), longint'(exp_bit));
            check(sample_tick == (m_cnt == 7), "R1", longint'(sample_tick), longint'(m_cnt == 7));
        end
    end

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_neg(2);
        rst_n = 1'b1;
    endtask

    task automatic load_word(logic [23:0] w);
        @(negedge clk);
        data_in = w;
        data_load = 1'b1;
        @(negedge clk);
        data_load = 1'b0;
    endtask

    task automatic count_ones(int n, output int ones);
        int seen;
        ones = 0;
        seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (sample_tick) begin
                seen++;
                if (bit_out) ones++;
            end
        end
    endtask

    task automatic density(string req, longint u);
        int ones;
        longint expct, diff;
        cur_req = req;
        count_ones(SKIP, ones);
        count_ones(NWIN, ones);
        expct = (longint'(NWIN) * u + HALF) >>> 20;
        diff = longint'(ones) - expct;
        if (diff < 0) diff = -diff;
        check(diff <= TOL, req, longint'(ones), expct);
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ticks;
        wait_neg(3);
        // R8: outputs quiet during reset
        check(bit_out == 1'b0, "R8", longint'(bit_out), 0);
        check(sample_tick == 1'b0, "R8", longint'(sample_tick), 0);
        rst_n = 1'b1;

        // R1: one tick per 8 clocks
        ticks = 0;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (sample_tick) ticks++;
        end
        check(ticks == 100, "R1", longint'(ticks), 100);

        // R2: offset binary, 20 bits
        res_hi = 1'b1; fmt_offset = 1'b1;
        load_word(24'h400000);
        density("R2", 64'h40000);
        load_word(24'hC00000);
        density("R2", 64'hC0000);

        // R6: data change without load is ignored
        @(negedge clk);
        data_in = 24'h000000;
        density("R6", 64'hC0000);

        // R4: two's complement coding
        fmt_offset = 1'b0;
        load_word(24'hC00000);
        density("R4", 64'h40000);
        load_word(24'h000000);
        density("R4", 64'h80000);

        // R3: 16-bit truncation
        fmt_offset = 1'b1; res_hi = 1'b0;
        load_word(24'h12345F);
        density("R3", 64'h12340);
        load_word(24'h8000FF);
        density("R3", 64'h80000);
        res_hi = 1'b1;

        // R5: synchronous clear, level by coding
        fmt_offset = 1'b0;
        load_word(24'h400000);
        @(negedge clk);
        clear = 1'b1;
        density("R5", 64'h80000);
        fmt_offset = 1'b1;
        density("R5", 64'h0);
        @(negedge clk);
        clear = 1'b0;
        density("R5", 64'h0);

        // R7: sleep silences and freezes, then resumes
        load_word(24'h400000);
        density("R7", 64'h40000);
        cur_req = "R7";
        @(negedge clk);
        sleep = 1'b1;
        ticks = 0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (bit_out) ticks++;
        end
        check(ticks == 0, "R7", longint'(ticks), 0);
        sleep = 1'b0;
        density("R7", 64'h40000);

        // R9: saturation at both ends of the range
        cur_req = "R9";
        do_reset();
        load_word(24'h000000);
        density("R9", 64'h0);
        do_reset();
        load_word(24'hFFFFFF);
        density("R9", 64'hFFFFF);

        wait_neg(4);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule